// File: doc/BRIEF.md
# External Interrupt Controller with Non-Maskable Input

This block watches a parameterised set of external interrupt pins and one non-maskable interrupt pin. Each pin is brought into a sampling clock domain through a two-flop synchroniser. There it can pass through a three-sample majority filter and is then tested for a rising, falling or either edge, or for a high or low level. Detections cross into the bus clock domain. Edges cross as toggles and levels cross as synchronised levels. A detection sets a sticky per-pin flag there.

The maskable pins share one interrupt request. That request is high while any flag is set together with its mask bit. Software reads the flag register to find the source. The non-maskable pin has its own sense field, filter bit, flag and request line. It has no mask and does not depend on the controller enable. Each maskable pin can also emit a one-cycle event pulse toward an event fabric. Configuration and status sit behind a small word-addressed write/read bus in the bus clock domain. The configuration is treated as quasi-static by the sampling logic.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero: the control word, sense settings, mask, flags, event enables, non-maskable sense (so no detection) and the non-maskable flag. `irq_o`, `nmi_irq_o` and `evt_o` are low.
- R2: Each maskable pin i has a 4-bit setting at address 1. The sense code is in bits [4i+2:4i]: 0 none, 1 rising, 2 falling, 3 either edge, 4 high level, 5 low level, 6 and 7 none.
- R3: Bit 4i+3 enables the filter for pin i. With the filter on, the value used is the majority of the last three synchronised samples, so a pulse lasting one sampling clock is rejected. With the filter off, that pulse is detected.
- R4: Writing to address 2 sets every mask bit whose data bit is one. Writing to address 3 clears every mask bit whose data bit is one. Zero bits change nothing, and both addresses read back the mask.
- R5: `irq_o` is high exactly while some pin has both its flag (address 4) and its mask bit set. It drops when the flag or the mask bit is cleared.
- R6: Writing a one to a bit of address 4 clears that flag. A detection on that pin in the same bus cycle wins, so the flag stays set.
- R7: Bit 0 of address 0 enables the controller. While it is zero, maskable pins set no flags and emit no events.
- R8: The non-maskable pin uses address 6, with the sense in bits [2:0] coded as in R2 and the filter in bit 3. Its detection sets its flag whatever the controller enable is.
- R9: The non-maskable flag (address 7, bit 0) drives `nmi_irq_o` directly, with no mask. Writing a one to bit 0 of address 7 clears it.
- R10: When event enable bit i (address 5) is set, `evt_o[i]` gives one bus-cycle pulse for each edge detection, or for the start of a level condition. When the bit is clear, no pulse occurs.
- R11: A pin change is reflected in the flag within 4 sampling plus 4 bus cycles without the filter, and within 6 sampling plus 4 bus cycles with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus and flag clock |
| smp_clk | input | 1 | Sampling clock for synchronisers, filters and detectors |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ext_pin_i | input | N_PINS | Maskable external interrupt pins |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin |
| bus_we_i | input | 1 | Write strobe, one bus cycle per write |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Shared request of the maskable pins |
| nmi_irq_o | output | 1 | Non-maskable request |
| evt_o | output | N_PINS | Per-pin event pulses |

## Verification
The hardest case to reach is a flag clear that lands in the same bus cycle as a fresh detection on that pin. The two clocks make the arrival cycle of an edge hard to predict from the ports. The stimulus uses a high-level sense and holds the pin high, so a detection is raised in every bus cycle. Any clear write then collides with one. The flag must still read one afterwards, and a clear after the pin drops must succeed. The one-sampling-cycle glitch used for the filter is driven on sampling-clock falling edges, so exactly one sampling edge sees it.

// File: rtl/eic_pkg.sv
package eic_pkg;
    // sense codes (shared by maskable and non-maskable pins)
    localparam logic [2:0] SNS_NONE = 3'd0;
    localparam logic [2:0] SNS_RISE = 3'd1;
    localparam logic [2:0] SNS_FALL = 3'd2;
    localparam logic [2:0] SNS_BOTH = 3'd3;
    localparam logic [2:0] SNS_HIGH = 3'd4;
    localparam logic [2:0] SNS_LOW  = 3'd5;

    // word addresses of the register bus
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CFG   = 3'd1;
    localparam logic [2:0] A_MSET  = 3'd2;
    localparam logic [2:0] A_MCLR  = 3'd3;
    localparam logic [2:0] A_FLAG  = 3'd4;
    localparam logic [2:0] A_EVEN  = 3'd5;
    localparam logic [2:0] A_NCFG  = 3'd6;
    localparam logic [2:0] A_NFLAG = 3'd7;

    function automatic logic sense_is_none(input logic [2:0] s);
        return (s == SNS_NONE) || (s > SNS_LOW);
    endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] outp;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = d_i;
        st_d.outp = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.outp;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [2:0] sense_i,
    input  logic       filt_i,
    output logic       lvl_o,
    output logic       tog_o
);
    typedef struct packed {
        logic [1:0] sy;
        logic [2:0] hist;
        logic       prev;
        logic       tog;
        logic       lvl;
    } det_t;

    det_t st_d, st_q;
    logic synced, maj, val, rise, fall, edge_hit;

    always_comb begin
        st_d    = st_q;
        st_d.sy = {st_q.sy[0], pin_i};
        synced  = st_q.sy[1];
        st_d.hist = {st_q.hist[1:0], synced};
        maj = (st_q.hist[0] & st_q.hist[1]) | (st_q.hist[0] & st_q.hist[2]) |
              (st_q.hist[1] & st_q.hist[2]);
        val  = filt_i ? maj : synced;
        rise = val & ~st_q.prev;
        fall = ~val & st_q.prev;
        case (sense_i)
            SNS_RISE: edge_hit = rise;
            SNS_FALL: edge_hit = fall;
            SNS_BOTH: edge_hit = rise | fall;
            default:  edge_hit = 1'b0;
        endcase
        st_d.prev = val;
        st_d.tog  = st_q.tog ^ edge_hit;
        st_d.lvl  = ((sense_i == SNS_HIGH) & val) | ((sense_i == SNS_LOW) & ~val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;
    assign tog_o = st_q.tog;

    // R2
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_is_none(sense_i) |=> (st_q.tog == $past(st_q.tog)) && !st_q.lvl);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              bus_clk,
    input  logic              smp_clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] ext_pin_i,
    input  logic              nmi_pin_i,
    input  logic              bus_we_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              nmi_irq_o,
    output logic [N_PINS-1:0] evt_o
);
    localparam int NS    = N_PINS + 1;   // maskable pins plus the non-maskable one
    localparam int CFG_W = 4 * N_PINS;

    typedef struct packed {
        logic              en;
        logic [CFG_W-1:0]  cfg;
        logic [N_PINS-1:0] mask;
        logic [N_PINS-1:0] flags;
        logic [N_PINS-1:0] even;
        logic [3:0]        ncfg;
        logic              nflag;
        logic [NS-1:0]     tog_p;
        logic [N_PINS-1:0] hit_p;
        logic [N_PINS-1:0] evt;
    } regs_t;

    regs_t st_d, st_q;

    logic [NS-1:0]     lvl_raw, tog_raw, lvl_s, tog_s, hit;
    logic [2*NS-1:0]   sy_out;
    logic [N_PINS-1:0] set_m, clr_f, start;
    logic [N_PINS-1:0] wd_n;

    // per-pin detectors in the sampling domain
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        eic_detect u_det (
            .clk     (smp_clk),
            .rst_n   (rst_n),
            .pin_i   (ext_pin_i[g]),
            .sense_i (st_q.cfg[4*g +: 3]),
            .filt_i  (st_q.cfg[4*g + 3]),
            .lvl_o   (lvl_raw[g]),
            .tog_o   (tog_raw[g])
        );
    end

    eic_detect u_nmi_det (
        .clk     (smp_clk),
        .rst_n   (rst_n),
        .pin_i   (nmi_pin_i),
        .sense_i (st_q.ncfg[2:0]),
        .filt_i  (st_q.ncfg[3]),
        .lvl_o   (lvl_raw[N_PINS]),
        .tog_o   (tog_raw[N_PINS])
    );

    // crossing into the bus domain
    eic_sync #(.W(2 * NS)) u_sync (
        .clk   (bus_clk),
        .rst_n (rst_n),
        .d_i   ({tog_raw, lvl_raw}),
        .q_o   (sy_out)
    );

    assign lvl_s = sy_out[NS-1:0];
    assign tog_s = sy_out[2*NS-1:NS];

    always_comb begin
        st_d  = st_q;
        wd_n  = bus_wdata_i[N_PINS-1:0];
        hit   = lvl_s | (tog_s ^ st_q.tog_p);
        start = hit[N_PINS-1:0] & ~st_q.hit_p;
        set_m = hit[N_PINS-1:0] & {N_PINS{st_q.en}};
        clr_f = (bus_we_i && bus_addr_i == A_FLAG) ? wd_n : '0;

        st_d.tog_p = tog_s;
        st_d.hit_p = hit[N_PINS-1:0];
        st_d.flags = (st_q.flags & ~clr_f) | set_m;
        st_d.nflag = (st_q.nflag & ~(bus_we_i && bus_addr_i == A_NFLAG && bus_wdata_i[0]))
                     | hit[N_PINS];
        st_d.evt   = start & st_q.even & {N_PINS{st_q.en}};

        if (bus_we_i) begin
            case (bus_addr_i)
                A_CTRL: st_d.en   = bus_wdata_i[0];
                A_CFG:  st_d.cfg  = bus_wdata_i[CFG_W-1:0];
                A_MSET: st_d.mask = st_q.mask | wd_n;
                A_MCLR: st_d.mask = st_q.mask & ~wd_n;
                A_EVEN: st_d.even = wd_n;
                A_NCFG: st_d.ncfg = bus_wdata_i[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL:          bus_rdata_o[0]          = st_q.en;
            A_CFG:           bus_rdata_o[CFG_W-1:0]  = st_q.cfg;
            A_MSET, A_MCLR:  bus_rdata_o[N_PINS-1:0] = st_q.mask;
            A_FLAG:          bus_rdata_o[N_PINS-1:0] = st_q.flags;
            A_EVEN:          bus_rdata_o[N_PINS-1:0] = st_q.even;
            A_NCFG:          bus_rdata_o[3:0]        = st_q.ncfg;
            A_NFLAG:         bus_rdata_o[0]          = st_q.nflag;
            default:         bus_rdata_o             = '0;
        endcase
    end

    assign irq_o     = |(st_q.flags & st_q.mask);
    assign nmi_irq_o = st_q.nflag;
    assign evt_o     = st_q.evt;

    // R4
    mask_set_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_MSET) |=>
        ((st_q.mask & $past(bus_wdata_i[N_PINS-1:0])) == $past(bus_wdata_i[N_PINS-1:0])));

    // R6
    flag_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        !(bus_we_i && bus_addr_i == A_FLAG) |=>
        ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    // R7
    disabled_no_flag_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        !st_q.en |=> ((st_q.flags & ~$past(st_q.flags)) == '0));

    // R8
    nmi_detect_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        hit[N_PINS] |=> st_q.nflag);
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
    localparam int N   = 4;
    localparam int LAT = 16;   // bus cycles, covers the R11 bound

    typedef struct packed {
        logic [2:0] sns;
        logic       filt;
        logic       p0;
        logic       p1;
        logic       exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 1'b0, 1'b1, 1'b1},
        '{3'd1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{3'd2, 1'b0, 1'b1, 1'b0, 1'b1},
        '{3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        '{3'd3, 1'b0, 1'b0, 1'b1, 1'b1},
        '{3'd3, 1'b0, 1'b1, 1'b0, 1'b1},
        '{3'd4, 1'b0, 1'b0, 1'b1, 1'b1},
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd5, 1'b0, 1'b1, 1'b0, 1'b1},
        '{3'd5, 1'b0, 1'b1, 1'b1, 1'b0},
        '{3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{3'd6, 1'b0, 1'b0, 1'b1, 1'b0},
        '{3'd7, 1'b0, 1'b1, 1'b0, 1'b0},
        '{3'd1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{3'd4, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    logic          bus_clk = 1'b0;
    logic          smp_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ext_pin = '0;
    logic          nmi_pin = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, nmi_irq;
    logic [N-1:0]  evt;

    int n_chk = 0;
    int n_fail = 0;
    int evt_cnt = 0;
    bit done = 1'b0;

    ext_irq_ctrl #(.N_PINS(N)) uut (
        .bus_clk(bus_clk), .smp_clk(smp_clk), .rst_n(rst_n),
        .ext_pin_i(ext_pin), .nmi_pin_i(nmi_pin),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .nmi_irq_o(nmi_irq), .evt_o(evt)
    );

    always #4 bus_clk = ~bus_clk;            // 125 MHz
    initial begin
        #3;
        forever #8 smp_clk = ~smp_clk;
    end

    always @(negedge bus_clk) if (rst_n) evt_cnt <= evt_cnt + $countones(evt);

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            report();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic glitch0();
        @(negedge smp_clk);
        ext_pin[0] = 1'b1;
        @(negedge smp_clk);
        ext_pin[0] = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        int base;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            check("R1 register reset", r, 32'h0);
        end
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        check("R1 nmi reset", {31'h0, nmi_irq}, 32'h0);
        check("R1 evt reset", {28'h0, evt}, 32'h0);

        // R8: after reset the non-maskable sense detects nothing
        nmi_pin = 1'b1; cyc(LAT);
        nmi_pin = 1'b0; cyc(LAT);
        rd(3'd7, r);
        check("R8 nmi no detect after reset", r, 32'h0);

        // table walk: R2, R3, R11 on pin 1
        wr(3'd0, 32'h1);
        for (int i = 0; i < NV; i++) begin
            wr(3'd1, {24'h0, VECS[i].filt, VECS[i].sns, 4'h0});
            ext_pin[1] = VECS[i].p0;
            cyc(LAT);
            wr(3'd4, 32'hF);
            cyc(2);
            ext_pin[1] = VECS[i].p1;
            cyc(LAT);
            rd(3'd4, r);
            check($sformatf("R2/R11 vector %0d flag", i), {31'h0, r[1]}, {31'h0, VECS[i].exp});
        end
        wr(3'd1, 32'h0);
        ext_pin[1] = 1'b0;
        cyc(LAT);
        wr(3'd4, 32'hF);

        // R4: mask set / clear
        wr(3'd2, 32'h5);
        rd(3'd2, r); check("R4 mask set", r, 32'h5);
        wr(3'd2, 32'h0);
        rd(3'd3, r); check("R4 zero set no effect", r, 32'h5);
        wr(3'd3, 32'h1);
        rd(3'd2, r); check("R4 mask clear", r, 32'h4);
        wr(3'd3, 32'h0);
        rd(3'd3, r); check("R4 zero clear no effect", r, 32'h4);

        // R5: shared request from pin 2
        wr(3'd1, 32'h100);                      // pin 2 rising
        ext_pin[2] = 1'b1; cyc(LAT);
        check("R5 irq on flag and mask", {31'h0, irq}, 32'h1);
        rd(3'd4, r); check("R5 flag identifies pin 2", r, 32'h4);
        wr(3'd3, 32'h4);
        check("R5 irq drops on mask clear", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h4);
        check("R5 irq back on mask set", {31'h0, irq}, 32'h1);
        wr(3'd4, 32'h4);
        check("R5 irq drops on flag clear", {31'h0, irq}, 32'h0);
        ext_pin[2] = 1'b0; cyc(LAT);
        check("R5 no irq on falling with rising sense", {31'h0, irq}, 32'h0);
        wr(3'd3, 32'hF);

        // R6: clear collides with held high level
        wr(3'd1, 32'h4);                        // pin 0 high level
        ext_pin[0] = 1'b1; cyc(LAT);
        wr(3'd4, 32'h1);
        rd(3'd4, r); check("R6 detection wins over clear", r, 32'h1);
        ext_pin[0] = 1'b0; cyc(LAT);
        wr(3'd4, 32'h1);
        rd(3'd4, r); check("R6 clear after level drops", r, 32'h0);

        // R7: controller disabled
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h1000);                     // pin 3 rising
        wr(3'd5, 32'h8);
        base = evt_cnt;
        ext_pin[3] = 1'b1; cyc(LAT);
        rd(3'd4, r); check("R7 no flag while disabled", r, 32'h0);
        #1 check("R7 no event while disabled", evt_cnt - base, 0);
        ext_pin[3] = 1'b0; cyc(LAT);
        wr(3'd5, 32'h0);

        // R8/R9: non-maskable with controller still off
        wr(3'd6, 32'h1);
        nmi_pin = 1'b1; cyc(LAT);
        check("R9 nmi request", {31'h0, nmi_irq}, 32'h1);
        rd(3'd7, r); check("R8 nmi flag with enable off", r, 32'h1);
        wr(3'd7, 32'h1);
        check("R9 nmi request cleared", {31'h0, nmi_irq}, 32'h0);
        nmi_pin = 1'b0; cyc(LAT);
        wr(3'd6, 32'h9);                        // rising, filtered
        @(negedge smp_clk); nmi_pin = 1'b1;
        @(negedge smp_clk); nmi_pin = 1'b0;
        cyc(LAT);
        rd(3'd7, r); check("R8 nmi filter rejects glitch", r, 32'h0);
        wr(3'd6, 32'h0);

        // R10: events
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h3);                        // pin 0 either edge
        wr(3'd5, 32'h1);
        cyc(LAT);
        base = evt_cnt;
        ext_pin[0] = 1'b1; cyc(LAT);
        ext_pin[0] = 1'b0; cyc(LAT);
        #1 check("R10 one pulse per edge", evt_cnt - base, 2);
        wr(3'd5, 32'h0);
        base = evt_cnt;
        ext_pin[0] = 1'b1; cyc(LAT);
        ext_pin[0] = 1'b0; cyc(LAT);
        #1 check("R10 no pulse when disabled", evt_cnt - base, 0);
        wr(3'd1, 32'h4);                        // high level
        wr(3'd5, 32'h1);
        base = evt_cnt;
        ext_pin[0] = 1'b1; cyc(LAT);
        #1 check("R10 single pulse at level start", evt_cnt - base, 1);
        ext_pin[0] = 1'b0; cyc(LAT);
        wr(3'd5, 32'h0);

        // R3: one-sampling-cycle glitch
        wr(3'd1, 32'h1);                        // rising, no filter
        cyc(LAT);
        wr(3'd4, 32'hF);
        glitch0(); cyc(LAT);
        rd(3'd4, r); check("R3 glitch seen without filter", r, 32'h1);
        wr(3'd1, 32'h9);                        // rising, filtered
        cyc(LAT);
        wr(3'd4, 32'hF);
        glitch0(); cyc(LAT);
        rd(3'd4, r); check("R3 glitch rejected with filter", r, 32'h0);

        done = 1'b1;
        report();
    end
endmodule